// File: doc/BRIEF.md
# Debug Control Register with Hit Dispatch

This block holds a six-bit debug control word that is written from the debug scan path in the test-clock domain. The write happens on the same scan access that loads a watchpoint register, and the same access reads the word back. The fields act on the core-clock side, so every write crosses into the core domain through a toggle request/acknowledge handshake. The core-domain copy of the word changes in one step, and only when the handshake commits it.

In the core domain the applied word does three things. It gates the raw comparator hit. It sends each unmasked hit either to a debug-state entry request or to an abort request. It also shapes the core's interrupt enable, debug request and debug acknowledge. A hit becomes a one-cycle pulse on its rising edge. Bit 5 is the comparator mask. Bit 4 selects the hit mode. Bit 3 is reserved. Bit 2 masks interrupts. Bit 1 forces the debug request and bit 0 forces the debug acknowledge.

Top module: `dbg_ctrl_reg`

## Requirements
- R1: While both resets are high, `rd_data` is 0 and every core-domain output is 0. After reset the applied word is all zero: hits are not masked, hits go to debug entry, interrupts pass through and nothing is forced.
- R2: A test-clock write with `wr_en` high loads `wr_data` into the read-back word at that edge. Bit 3 of `rd_data` always reads 0, whatever was written to it.
- R3: The core-domain effect of a write does not change the core outputs in the first core cycle after the write edge. Until the handshake commits the word, the old applied value stays in force.
- R4: While applied bit 5 is 1, neither `dbg_entry_req` nor `abort_req` is asserted, whatever `cmp_hit` does.
- R5: With bit 5 = 0 and bit 4 = 0, a rising edge of `cmp_hit` makes `dbg_entry_req` high for exactly one core cycle, registered one cycle after the edge. A hit that stays high gives no further pulse.
- R6: With bit 5 = 0 and bit 4 = 1, a rising edge of `cmp_hit` makes `abort_req` high for exactly one core cycle instead. The two requests are never high together.
- R7: `irq_en_out` is `core_irq_en` registered, forced to 0 while applied bit 2 is 1.
- R8: `dbg_req_out` is the registered OR of applied bit 1 and `core_dbg_req`.
- R9: `dbg_ack_out` is the registered OR of applied bit 0 and `core_dbg_ack`.
- R10: Writes that arrive while a transfer is in flight are not lost. Once the handshake goes quiet, the core applies the last value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_clk | input | 1 | Test clock |
| tck_rst | input | 1 | Synchronous active-high reset, test-clock domain |
| wr_en | input | 1 | Write strobe from the scan path |
| wr_data | input | 6 | Value to write |
| rd_data | output | 6 | Read-back word, test-clock domain |
| core_clk | input | 1 | Core clock |
| core_rst | input | 1 | Synchronous active-high reset, core-clock domain |
| cmp_hit | input | 1 | Raw breakpoint/watchpoint comparator hit |
| core_irq_en | input | 1 | Core's normal interrupt enable |
| core_dbg_req | input | 1 | Core's own debug request |
| core_dbg_ack | input | 1 | Core's own debug acknowledge |
| dbg_entry_req | output | 1 | One-cycle request to enter debug state |
| abort_req | output | 1 | One-cycle request for an abort exception |
| irq_en_out | output | 1 | Interrupt enable after masking |
| dbg_req_out | output | 1 | Debug request after forcing |
| dbg_ack_out | output | 1 | Debug acknowledge after forcing |

## Verification
Hits are driven once with the mode bit clear and once with it set. This separates the two dispatch paths and shows that a held hit pulses only once. The same hit is then held for several cycles with the mask bit set, which would show any leak through the gate. Each forcing bit is tried against the core's own signal in both states, which tells a forcing OR apart from a plain pass-through. The forced value is also sampled right after the write, so a bypass of the handshake would show up. A burst of three back-to-back writes confirms that only the last one lands in the core domain.

// File: rtl/dbgc_pkg.sv
package dbgc_pkg;
  localparam int unsigned CTRL_W   = 6;
  localparam int unsigned B_MASK   = 5;
  localparam int unsigned B_MODE   = 4;
  localparam int unsigned B_RSVD   = 3;
  localparam int unsigned B_IRQOFF = 2;
  localparam int unsigned B_FREQ   = 1;
  localparam int unsigned B_FACK   = 0;

  typedef logic [CTRL_W-1:0] ctrl_t;

  function automatic ctrl_t scrub(input ctrl_t v);
    ctrl_t r;
    r = v;
    r[B_RSVD] = 1'b0;
    return r;
  endfunction
endpackage

// File: rtl/dbgc_sync.sv
module dbgc_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned WIDTH  = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) chain[0] <= '0;
    else     chain[0] <= d;
  end

  for (genvar i = 1; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) chain[i] <= '0;
      else     chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/dbgc_tck_side.sv
module dbgc_tck_side
  import dbgc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  wr_en,
  input  ctrl_t wr_data,
  input  logic  ack_sync,
  output ctrl_t hold,
  output ctrl_t snap,
  output logic  req_tog
);
  logic  pend;
  logic  busy;
  ctrl_t clean;

  assign busy  = req_tog ^ ack_sync;
  assign clean = scrub(wr_data);

  always_ff @(posedge clk) begin
    if (rst) begin
      hold    <= '0;
      snap    <= '0;
      req_tog <= 1'b0;
      pend    <= 1'b0;
    end else begin
      if (wr_en) hold <= clean;
      if (!busy && (pend || wr_en)) begin
        snap    <= wr_en ? clean : hold;
        req_tog <= ~req_tog;
        pend    <= 1'b0;
      end else if (wr_en) begin
        pend <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/dbgc_core_side.sv
module dbgc_core_side
  import dbgc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  req_sync,
  input  ctrl_t snap,
  output logic  ack_tog,
  output ctrl_t applied
);
  always_ff @(posedge clk) begin
    if (rst) begin
      applied <= '0;
      ack_tog <= 1'b0;
    end else if (req_sync != ack_tog) begin
      applied <= snap;
      ack_tog <= req_sync;
    end
  end
endmodule

// File: rtl/dbgc_hit_dispatch.sv
module dbgc_hit_dispatch
  import dbgc_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  ctrl_t applied,
  input  logic  cmp_hit,
  input  logic  core_irq_en,
  input  logic  core_dbg_req,
  input  logic  core_dbg_ack,
  output logic  dbg_entry_req,
  output logic  abort_req,
  output logic  irq_en_out,
  output logic  dbg_req_out,
  output logic  dbg_ack_out
);
  logic hit_m;
  logic hit_q;
  logic hit_rise;

  assign hit_m    = cmp_hit & ~applied[B_MASK];
  assign hit_rise = hit_m & ~hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hit_q         <= 1'b0;
      dbg_entry_req <= 1'b0;
      abort_req     <= 1'b0;
      irq_en_out    <= 1'b0;
      dbg_req_out   <= 1'b0;
      dbg_ack_out   <= 1'b0;
    end else begin
      hit_q         <= hit_m;
      dbg_entry_req <= hit_rise & ~applied[B_MODE];
      abort_req     <= hit_rise &  applied[B_MODE];
      irq_en_out    <= core_irq_en & ~applied[B_IRQOFF];
      dbg_req_out   <= core_dbg_req | applied[B_FREQ];
      dbg_ack_out   <= core_dbg_ack | applied[B_FACK];
    end
  end
endmodule

// File: rtl/dbg_ctrl_reg.sv
module dbg_ctrl_reg
  import dbgc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              tck_clk,
  input  logic              tck_rst,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  output logic [CTRL_W-1:0] rd_data,
  input  logic              core_clk,
  input  logic              core_rst,
  input  logic              cmp_hit,
  input  logic              core_irq_en,
  input  logic              core_dbg_req,
  input  logic              core_dbg_ack,
  output logic              dbg_entry_req,
  output logic              abort_req,
  output logic              irq_en_out,
  output logic              dbg_req_out,
  output logic              dbg_ack_out
);
  ctrl_t hold, snap, applied;
  logic  req_tog, req_sync, ack_tog, ack_sync;

  dbgc_tck_side u_tck (
    .clk(tck_clk), .rst(tck_rst), .wr_en(wr_en), .wr_data(wr_data),
    .ack_sync(ack_sync), .hold(hold), .snap(snap), .req_tog(req_tog)
  );

  dbgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_req_sync (
    .clk(core_clk), .rst(core_rst), .d(req_tog), .q(req_sync)
  );

  dbgc_sync #(.STAGES(SYNC_STAGES), .WIDTH(1)) u_ack_sync (
    .clk(tck_clk), .rst(tck_rst), .d(ack_tog), .q(ack_sync)
  );

  dbgc_core_side u_core (
    .clk(core_clk), .rst(core_rst), .req_sync(req_sync), .snap(snap),
    .ack_tog(ack_tog), .applied(applied)
  );

  dbgc_hit_dispatch u_disp (
    .clk(core_clk), .rst(core_rst), .applied(applied), .cmp_hit(cmp_hit),
    .core_irq_en(core_irq_en), .core_dbg_req(core_dbg_req),
    .core_dbg_ack(core_dbg_ack), .dbg_entry_req(dbg_entry_req),
    .abort_req(abort_req), .irq_en_out(irq_en_out),
    .dbg_req_out(dbg_req_out), .dbg_ack_out(dbg_ack_out)
  );

  assign rd_data = hold;
endmodule

// File: rtl/dbg_ctrl_reg_checker.sv
module dbg_ctrl_reg_checker (
  input logic       tck_clk,
  input logic       tck_rst,
  input logic       core_clk,
  input logic       core_rst,
  input logic [5:0] rd_data,
  input logic [5:0] applied,
  input logic [5:0] snap,
  input logic       req_tog,
  input logic       ack_sync,
  input logic       core_dbg_req,
  input logic       core_dbg_ack,
  input logic       dbg_entry_req,
  input logic       abort_req,
  input logic       irq_en_out,
  input logic       dbg_req_out,
  input logic       dbg_ack_out
);
  assert_rsvd_zero_R2: assert property (@(posedge tck_clk) disable iff (tck_rst)
    rd_data[3] == 1'b0);

  assert_snap_hold_R3: assert property (@(posedge tck_clk) disable iff (tck_rst)
    (req_tog != ack_sync) |=> $stable(snap));

  assert_mask_R4: assert property (@(posedge core_clk) disable iff (core_rst)
    applied[5] |=> !(dbg_entry_req || abort_req));

  assert_entry_pulse_R5: assert property (@(posedge core_clk) disable iff (core_rst)
    dbg_entry_req |=> !dbg_entry_req);

  assert_abort_pulse_R6: assert property (@(posedge core_clk) disable iff (core_rst)
    abort_req |=> !abort_req);

  assert_exclusive_R6: assert property (@(posedge core_clk) disable iff (core_rst)
    !(dbg_entry_req && abort_req));

  assert_irq_off_R7: assert property (@(posedge core_clk) disable iff (core_rst)
    applied[2] |=> !irq_en_out);

  assert_req_pass_R8: assert property (@(posedge core_clk) disable iff (core_rst)
    core_dbg_req |=> dbg_req_out);

  assert_ack_pass_R9: assert property (@(posedge core_clk) disable iff (core_rst)
    core_dbg_ack |=> dbg_ack_out);
endmodule

bind dbg_ctrl_reg dbg_ctrl_reg_checker u_checker (
  .tck_clk(tck_clk), .tck_rst(tck_rst), .core_clk(core_clk), .core_rst(core_rst),
  .rd_data(rd_data), .applied(applied), .snap(snap), .req_tog(req_tog),
  .ack_sync(ack_sync), .core_dbg_req(core_dbg_req), .core_dbg_ack(core_dbg_ack),
  .dbg_entry_req(dbg_entry_req), .abort_req(abort_req), .irq_en_out(irq_en_out),
  .dbg_req_out(dbg_req_out), .dbg_ack_out(dbg_ack_out)
);

// File: tb/dbg_ctrl_reg_bench.sv
module dbg_ctrl_reg_bench;
  logic       tck_clk = 0, tck_rst = 1, wr_en = 0;
  logic [5:0] wr_data = '0, rd_data;
  logic       core_clk = 0, core_rst = 1;
  logic       cmp_hit = 0, core_irq_en = 0, core_dbg_req = 0, core_dbg_ack = 0;
  logic       dbg_entry_req, abort_req, irq_en_out, dbg_req_out, dbg_ack_out;
  int         total = 0, bad = 0;

  always #2.5 core_clk = ~core_clk;
  always #16.5 tck_clk = ~tck_clk;

  dbg_ctrl_reg u_dbg_ctrl_reg (
    .tck_clk(tck_clk), .tck_rst(tck_rst), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .core_clk(core_clk), .core_rst(core_rst),
    .cmp_hit(cmp_hit), .core_irq_en(core_irq_en), .core_dbg_req(core_dbg_req),
    .core_dbg_ack(core_dbg_ack), .dbg_entry_req(dbg_entry_req),
    .abort_req(abort_req), .irq_en_out(irq_en_out),
    .dbg_req_out(dbg_req_out), .dbg_ack_out(dbg_ack_out)
  );

  task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic do_write(input logic [5:0] v);
    @(negedge tck_clk); wr_en = 1; wr_data = v;
    @(negedge tck_clk); wr_en = 0;
  endtask

  task automatic settle();
    repeat (16) @(posedge tck_clk);
    @(negedge core_clk);
  endtask

  task automatic core_tick();
    @(negedge core_clk);
  endtask

  task automatic test_reset();
    repeat (4) @(posedge tck_clk);
    @(negedge core_clk);
    check("R1 rd_data", rd_data, 6'h00);
    check("R1 outputs", {1'b0, dbg_entry_req, abort_req, irq_en_out, dbg_req_out, dbg_ack_out}, 6'h00);
    @(negedge tck_clk); tck_rst = 0;
    @(negedge core_clk); core_rst = 0;
    core_irq_en = 1;
    core_tick(); core_tick();
    check("R1 idle outputs", {1'b0, dbg_entry_req, abort_req, irq_en_out, dbg_req_out, dbg_ack_out}, 6'h04);
  endtask

  task automatic test_readback();
    @(negedge tck_clk); wr_en = 1; wr_data = 6'h3F;
    @(posedge tck_clk); #1;
    check("R2 rsvd reads zero", rd_data, 6'h37);
    @(negedge tck_clk); wr_en = 0;
    do_write(6'h00);
    check("R2 rewrite", rd_data, 6'h00);
    settle();
  endtask

  task automatic test_debug_hit();
    cmp_hit = 1; core_tick();
    check("R5 entry pulse", {dbg_entry_req, abort_req}, 2'b10);
    core_tick();
    check("R5 single cycle", {dbg_entry_req, abort_req}, 2'b00);
    core_tick();
    check("R5 held hit no repeat", {dbg_entry_req, abort_req}, 2'b00);
    cmp_hit = 0; core_tick();
  endtask

  task automatic test_abort_hit();
    do_write(6'h10); settle();
    cmp_hit = 1; core_tick();
    check("R6 abort pulse", {dbg_entry_req, abort_req}, 2'b01);
    core_tick();
    check("R6 single cycle", {dbg_entry_req, abort_req}, 2'b00);
    cmp_hit = 0; core_tick();
  endtask

  task automatic test_mask();
    do_write(6'h30); settle();
    cmp_hit = 1;
    for (int i = 0; i < 4; i++) begin
      core_tick();
      check("R4 masked hit", {dbg_entry_req, abort_req}, 2'b00);
    end
    cmp_hit = 0;
    do_write(6'h00); settle();
  endtask

  task automatic test_irq();
    core_irq_en = 1;
    do_write(6'h04); settle();
    check("R7 irq forced low", irq_en_out, 1'b0);
    do_write(6'h00); settle();
    check("R7 irq pass", irq_en_out, 1'b1);
    core_irq_en = 0; core_tick();
    check("R7 irq pass low", irq_en_out, 1'b0);
    core_irq_en = 1; core_tick();
  endtask

  task automatic test_force_req();
    core_dbg_req = 1; core_tick();
    check("R8 own request", dbg_req_out, 1'b1);
    core_dbg_req = 0; core_tick();
    check("R8 no request", dbg_req_out, 1'b0);
    @(negedge tck_clk); wr_en = 1; wr_data = 6'h02;
    @(posedge tck_clk); @(negedge core_clk);
    check("R3 old value holds", dbg_req_out, 1'b0);
    @(negedge tck_clk); wr_en = 0;
    settle();
    check("R8 forced request", dbg_req_out, 1'b1);
    do_write(6'h00); settle();
  endtask

  task automatic test_force_ack();
    core_dbg_ack = 1; core_tick();
    check("R9 own ack", dbg_ack_out, 1'b1);
    core_dbg_ack = 0;
    @(negedge tck_clk); wr_en = 1; wr_data = 6'h01;
    @(posedge tck_clk); @(negedge core_clk);
    check("R3 ack not yet forced", dbg_ack_out, 1'b0);
    @(negedge tck_clk); wr_en = 0;
    settle();
    check("R9 forced ack", dbg_ack_out, 1'b1);
    do_write(6'h00); settle();
  endtask

  task automatic test_burst();
    core_irq_en = 1;
    @(negedge tck_clk); wr_en = 1; wr_data = 6'h01;
    @(negedge tck_clk); wr_data = 6'h02;
    @(negedge tck_clk); wr_data = 6'h04;
    @(negedge tck_clk); wr_en = 0;
    settle();
    check("R10 last write applied", {1'b0, irq_en_out, dbg_req_out, dbg_ack_out}, 4'b0000);
    check("R10 readback", rd_data, 6'h04);
    do_write(6'h00); settle();
    check("R10 cleared", {1'b0, irq_en_out, dbg_req_out, dbg_ack_out}, 4'b0100);
  endtask

  initial begin
    #500000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    test_reset();
    test_readback();
    test_debug_hit();
    test_abort_hit();
    test_mask();
    test_irq();
    test_force_req();
    test_force_ack();
    test_burst();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule